// File: doc/BRIEF.md
# Clock-Module Event Interrupt Controller

This block watches the status outputs of a clock-synchronisation module and turns eight kinds of change into sticky event bits. The inputs it watches are the per-reference availability flags, the master/slave reference activity flag, the DPLL mode word, the index of the active reference, and the loss-of-signal and loss-of-lock flags of that active reference. Each input is compared with its registered copy from the previous cycle. A direction-specific or any-change transition sets its event bit, and the bit then stays set until software reads the event register.

An enable register gates each event bit onto one registered, active-high interrupt line. Masking only affects the line: events are logged whether or not their enable bit is set. A small register port lets the host read the status, event and enable registers and write the enable register. Reading the event register returns its contents and clears all bits in the same cycle. An event that arrives in the cycle of that read is kept.

The register port is a plain command port, not a stream. A read or write request is accepted in every cycle, with no back-pressure. Read data comes back exactly one cycle after the request and is flagged by a one-cycle valid pulse.

Top module: `clkmod_evt_irq`

## Requirements
- R1: Event bit 0 sets when at least one reference availability flag changes from 1 to 0 between consecutive cycles.
- R2: Event bit 1 sets when at least one reference availability flag changes from 0 to 1 between consecutive cycles.
- R3: Event bit 2 sets when the master/slave activity flag falls, and event bit 3 sets when it rises.
- R4: The status register at address 0x11 reads as {mode word, loss-of-lock, loss-of-signal}, with loss-of-signal in bit 0 and loss-of-lock in bit 1, as registered in the previous cycle. Event bit 4 sets on any change of that value.
- R5: Event bit 5 sets on any change of the active-reference index.
- R6: Event bit 6 sets on a rising loss-of-signal flag, and event bit 7 sets on a rising loss-of-lock flag. A fault-driven reference switch therefore sets bit 5, bit 4, and bit 6 or bit 7.
- R7: Event bits set and stay set whatever the enable register holds.
- R8: The interrupt line is high exactly when some event bit and its enable bit are both 1. It follows the register contents with no extra cycle of lag.
- R9: A read of address 0x12 returns the event register one cycle later, with the valid pulse, and leaves all bits clear. Without a read, the bits hold.
- R10: An event detected in the same cycle as a read of address 0x12 stays set after the clear and is not part of the returned value.
- R11: The enable register at address 0x13 takes the write data and reads back unchanged. Writes to any other address change nothing.
- R12: Reset clears the event, enable, interrupt and read outputs. The first cycle after reset only loads the input copies and logs no event.
- R13: A read of any address other than 0x11, 0x12 and 0x13 returns zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| ref_avail_i | input | NUM_REFS | Availability flag of each reference |
| msref_active_i | input | 1 | Master/slave reference shows activity |
| mode_i | input | MODE_W | DPLL mode status word |
| act_ref_i | input | IDX_W | Index of the active reference |
| los_i | input | 1 | Loss of signal on the active reference |
| lol_i | input | 1 | Loss of lock on the active reference |
| host_rd_i | input | 1 | Read request |
| host_wr_i | input | 1 | Write request |
| host_addr_i | input | ADDR_W | Register address |
| host_wdata_i | input | 8 | Write data |
| host_rdata_o | output | 8 | Read data, one cycle after the request |
| host_rvalid_o | output | 1 | Read data valid pulse |
| irq_o | output | 1 | Interrupt, active high |

## Verification
A stale or stuck input copy shows up at the very next read of 0x12 as a missing or extra event bit. The same fault also shows in the status readback at 0x11, because that register is the input copy itself. A corrupted enable or event bit moves the interrupt line at the next clock edge, and an enable fault also appears on the next read of 0x13. A clear that is missed or applied too broadly shows on the second of two back-to-back event reads, or in the read that follows an event landing on the clear cycle.

// File: rtl/clkmod_evt_pkg.sv
package clkmod_evt_pkg;

  localparam int DATA_W  = 8;
  localparam int NUM_EVT = 8;

  localparam logic [7:0] ADDR_STATUS = 8'h11;
  localparam logic [7:0] ADDR_EVENT  = 8'h12;
  localparam logic [7:0] ADDR_ENABLE = 8'h13;

  localparam int EVB_REF_LOST   = 0;
  localparam int EVB_REF_FOUND  = 1;
  localparam int EVB_MS_IDLE    = 2;
  localparam int EVB_MS_BUSY    = 3;
  localparam int EVB_STAT_CHG   = 4;
  localparam int EVB_ACTREF_CHG = 5;
  localparam int EVB_LOS        = 6;
  localparam int EVB_LOL        = 7;

  typedef logic [NUM_EVT-1:0] evt_vec_t;
  typedef logic [DATA_W-1:0]  data_t;

endpackage

// File: rtl/clkmod_evt_detect.sv
module clkmod_evt_detect
  import clkmod_evt_pkg::*;
#(
  parameter int NUM_REFS = 4,
  parameter int MODE_W   = 6,
  parameter int IDX_W    = 2,
  localparam int STAT_W  = MODE_W + 2
) (
  input  logic                clk_i,
  input  logic                rst_ni,
  input  logic [NUM_REFS-1:0] ref_avail_i,
  input  logic                msref_active_i,
  input  logic [MODE_W-1:0]   mode_i,
  input  logic [IDX_W-1:0]    act_ref_i,
  input  logic                los_i,
  input  logic                lol_i,
  output evt_vec_t            pulse_o,
  output logic [STAT_W-1:0]   stat_o,
  output logic                armed_o
);

  logic [NUM_REFS-1:0] avail_q;
  logic [NUM_REFS-1:0] ref_lost;
  logic [NUM_REFS-1:0] ref_found;
  logic                act_q;
  logic [IDX_W-1:0]    idx_q;
  logic [STAT_W-1:0]   stat_now;
  logic [STAT_W-1:0]   stat_q;
  logic                armed_q;
  evt_vec_t            raw;

  assign stat_now = {mode_i, lol_i, los_i};

  for (genvar r = 0; r < NUM_REFS; r++) begin : g_ref
    assign ref_lost[r]  = avail_q[r] & ~ref_avail_i[r];
    assign ref_found[r] = ~avail_q[r] & ref_avail_i[r];
  end

  always_comb begin
    raw                 = '0;
    raw[EVB_REF_LOST]   = |ref_lost;
    raw[EVB_REF_FOUND]  = |ref_found;
    raw[EVB_MS_IDLE]    = act_q & ~msref_active_i;
    raw[EVB_MS_BUSY]    = ~act_q & msref_active_i;
    raw[EVB_STAT_CHG]   = (stat_now != stat_q);
    raw[EVB_ACTREF_CHG] = (act_ref_i != idx_q);
    raw[EVB_LOS]        = los_i & ~stat_q[0];
    raw[EVB_LOL]        = lol_i & ~stat_q[1];
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      avail_q <= '0;
      act_q   <= 1'b0;
      idx_q   <= '0;
      stat_q  <= '0;
      armed_q <= 1'b0;
    end else begin
      avail_q <= ref_avail_i;
      act_q   <= msref_active_i;
      idx_q   <= act_ref_i;
      stat_q  <= stat_now;
      armed_q <= 1'b1;
    end
  end

  assign pulse_o = armed_q ? raw : '0;
  assign stat_o  = stat_q;
  assign armed_o = armed_q;

endmodule

// File: rtl/clkmod_evt_store.sv
module clkmod_evt_store
  import clkmod_evt_pkg::*;
(
  input  logic     clk_i,
  input  logic     rst_ni,
  input  evt_vec_t pulse_i,
  input  logic     clr_i,
  input  logic     en_wr_i,
  input  evt_vec_t en_wdata_i,
  output evt_vec_t evt_o,
  output evt_vec_t en_o,
  output logic     irq_o
);

  evt_vec_t evt_q, evt_d;
  evt_vec_t en_q, en_d;
  logic     irq_q;

  always_comb begin
    evt_d = (clr_i ? '0 : evt_q) | pulse_i;
    en_d  = en_wr_i ? en_wdata_i : en_q;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      evt_q <= '0;
      en_q  <= '0;
      irq_q <= 1'b0;
    end else begin
      evt_q <= evt_d;
      en_q  <= en_d;
      irq_q <= |(evt_d & en_d);
    end
  end

  assign evt_o = evt_q;
  assign en_o  = en_q;
  assign irq_o = irq_q;

endmodule

// File: rtl/clkmod_evt_regport.sv
module clkmod_evt_regport
  import clkmod_evt_pkg::*;
#(
  parameter int ADDR_W = 8,
  parameter int STAT_W = 8
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              rd_i,
  input  logic              wr_i,
  input  logic [ADDR_W-1:0] addr_i,
  input  data_t             wdata_i,
  input  evt_vec_t          evt_i,
  input  evt_vec_t          en_i,
  input  logic [STAT_W-1:0] stat_i,
  output logic              clr_o,
  output logic              en_wr_o,
  output evt_vec_t          en_wdata_o,
  output data_t             rdata_o,
  output logic              rvalid_o
);

  localparam logic [ADDR_W-1:0] A_STAT = ADDR_W'(ADDR_STATUS);
  localparam logic [ADDR_W-1:0] A_EVT  = ADDR_W'(ADDR_EVENT);
  localparam logic [ADDR_W-1:0] A_EN   = ADDR_W'(ADDR_ENABLE);

  data_t rd_sel;
  data_t rdata_q;
  logic  rvalid_q;

  assign clr_o      = rd_i && (addr_i == A_EVT);
  assign en_wr_o    = wr_i && (addr_i == A_EN);
  assign en_wdata_o = wdata_i;

  always_comb begin
    case (addr_i)
      A_STAT:  rd_sel = DATA_W'(stat_i);
      A_EVT:   rd_sel = evt_i;
      A_EN:    rd_sel = en_i;
      default: rd_sel = '0;
    endcase
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      rdata_q  <= '0;
      rvalid_q <= 1'b0;
    end else begin
      rvalid_q <= rd_i;
      rdata_q  <= rd_i ? rd_sel : '0;
    end
  end

  assign rdata_o  = rdata_q;
  assign rvalid_o = rvalid_q;

endmodule

// File: rtl/clkmod_evt_irq.sv
module clkmod_evt_irq
  import clkmod_evt_pkg::*;
#(
  parameter int NUM_REFS  = 4,
  parameter int MODE_W    = 6,
  parameter int ADDR_W    = 8,
  localparam int IDX_W    = (NUM_REFS > 1) ? $clog2(NUM_REFS) : 1,
  localparam int STAT_W   = MODE_W + 2
) (
  input  logic                clk_i,
  input  logic                rst_ni,
  input  logic [NUM_REFS-1:0] ref_avail_i,
  input  logic                msref_active_i,
  input  logic [MODE_W-1:0]   mode_i,
  input  logic [IDX_W-1:0]    act_ref_i,
  input  logic                los_i,
  input  logic                lol_i,
  input  logic                host_rd_i,
  input  logic                host_wr_i,
  input  logic [ADDR_W-1:0]   host_addr_i,
  input  logic [7:0]          host_wdata_i,
  output logic [7:0]          host_rdata_o,
  output logic                host_rvalid_o,
  output logic                irq_o
);

  evt_vec_t          pulse;
  evt_vec_t          evt_q;
  evt_vec_t          en_q;
  evt_vec_t          en_wdata;
  logic [STAT_W-1:0] stat_q;
  logic              armed_q;
  logic              clr;
  logic              en_wr;

  clkmod_evt_detect #(
    .NUM_REFS (NUM_REFS),
    .MODE_W   (MODE_W),
    .IDX_W    (IDX_W)
  ) u_detect (
    .clk_i          (clk_i),
    .rst_ni         (rst_ni),
    .ref_avail_i    (ref_avail_i),
    .msref_active_i (msref_active_i),
    .mode_i         (mode_i),
    .act_ref_i      (act_ref_i),
    .los_i          (los_i),
    .lol_i          (lol_i),
    .pulse_o        (pulse),
    .stat_o         (stat_q),
    .armed_o        (armed_q)
  );

  clkmod_evt_store u_store (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .pulse_i    (pulse),
    .clr_i      (clr),
    .en_wr_i    (en_wr),
    .en_wdata_i (en_wdata),
    .evt_o      (evt_q),
    .en_o       (en_q),
    .irq_o      (irq_o)
  );

  clkmod_evt_regport #(
    .ADDR_W (ADDR_W),
    .STAT_W (STAT_W)
  ) u_regport (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .rd_i       (host_rd_i),
    .wr_i       (host_wr_i),
    .addr_i     (host_addr_i),
    .wdata_i    (host_wdata_i),
    .evt_i      (evt_q),
    .en_i       (en_q),
    .stat_i     (stat_q),
    .clr_o      (clr),
    .en_wr_o    (en_wr),
    .en_wdata_o (en_wdata),
    .rdata_o    (host_rdata_o),
    .rvalid_o   (host_rvalid_o)
  );

endmodule

// File: rtl/clkmod_evt_irq_chk.sv
module clkmod_evt_irq_chk
  import clkmod_evt_pkg::*;
#(
  parameter int NUM_REFS = 4,
  parameter int ADDR_W   = 8,
  parameter int STAT_W   = 8
) (
  input logic                clk_i,
  input logic                rst_ni,
  input logic [NUM_REFS-1:0] ref_avail_i,
  input logic                los_i,
  input logic                host_rd_i,
  input logic                host_wr_i,
  input logic [ADDR_W-1:0]   host_addr_i,
  input logic [7:0]          host_wdata_i,
  input logic                host_rvalid_o,
  input logic                irq_o,
  input evt_vec_t            evt_q,
  input evt_vec_t            en_q,
  input evt_vec_t            pulse,
  input logic                armed_q,
  input logic [STAT_W-1:0]   stat_q
);

  logic rd_evt;
  logic wr_en;
  assign rd_evt = host_rd_i && (host_addr_i == ADDR_W'(ADDR_EVENT));
  assign wr_en  = host_wr_i && (host_addr_i == ADDR_W'(ADDR_ENABLE));

  // R1
  a_r1_ref_lost: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (armed_q && |($past(ref_avail_i) & ~ref_avail_i)) |=> evt_q[EVB_REF_LOST]);

  // R6
  a_r6_los_rise: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (armed_q && los_i && !stat_q[0]) |=> evt_q[EVB_LOS]);

  // R8
  a_r8_irq_follows: assert property (@(posedge clk_i) disable iff (!rst_ni)
    irq_o == |(evt_q & en_q));

  // R7 and R9: bits hold when no read clears them
  a_r9_sticky: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !rd_evt |=> ((evt_q & $past(evt_q)) == $past(evt_q)));

  // R10: after a clear only the same-cycle events remain
  a_r10_clear_keeps_new: assert property (@(posedge clk_i) disable iff (!rst_ni)
    rd_evt |=> (evt_q == $past(pulse)));

  // R9
  a_r9_rvalid_rise: assert property (@(posedge clk_i) disable iff (!rst_ni)
    host_rd_i |=> host_rvalid_o);
  a_r9_rvalid_idle: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !host_rd_i |=> !host_rvalid_o);

  // R11
  a_r11_en_write: assert property (@(posedge clk_i) disable iff (!rst_ni)
    wr_en |=> (en_q == $past(host_wdata_i)));
  a_r11_en_hold: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !wr_en |=> $stable(en_q));

  // R12
  a_r12_unarmed_quiet: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !armed_q |-> (pulse == '0));

endmodule

bind clkmod_evt_irq clkmod_evt_irq_chk #(
  .NUM_REFS (NUM_REFS),
  .ADDR_W   (ADDR_W),
  .STAT_W   (STAT_W)
) u_chk (
  .clk_i         (clk_i),
  .rst_ni        (rst_ni),
  .ref_avail_i   (ref_avail_i),
  .los_i         (los_i),
  .host_rd_i     (host_rd_i),
  .host_wr_i     (host_wr_i),
  .host_addr_i   (host_addr_i),
  .host_wdata_i  (host_wdata_i),
  .host_rvalid_o (host_rvalid_o),
  .irq_o         (irq_o),
  .evt_q         (evt_q),
  .en_q          (en_q),
  .pulse         (pulse),
  .armed_q       (armed_q),
  .stat_q        (stat_q)
);

// File: tb/clkmod_evt_irq_tb.sv
`timescale 1ns/1ps
module clkmod_evt_irq_tb;

  logic       clk_i = 1'b0;
  logic       rst_ni = 1'b0;
  logic [3:0] ref_avail_i = '0;
  logic       msref_active_i = 1'b0;
  logic [5:0] mode_i = '0;
  logic [1:0] act_ref_i = '0;
  logic       los_i = 1'b0;
  logic       lol_i = 1'b0;
  logic       host_rd_i = 1'b0;
  logic       host_wr_i = 1'b0;
  logic [7:0] host_addr_i = '0;
  logic [7:0] host_wdata_i = '0;
  logic [7:0] host_rdata_o;
  logic       host_rvalid_o;
  logic       irq_o;

  int n_chk = 0;
  int n_fail = 0;

  // bench-side model of the register contents
  logic [3:0] m_av = '0;
  logic       m_ac = 1'b0;
  logic [5:0] m_md = '0;
  logic [1:0] m_ix = '0;
  logic       m_ls = 1'b0;
  logic       m_ll = 1'b0;
  logic [7:0] m_evt = '0;
  logic [7:0] m_en = '0;
  logic       m_armed = 1'b0;

  always #2.5 clk_i = ~clk_i;

  clkmod_evt_irq u_dut (
    .clk_i          (clk_i),
    .rst_ni         (rst_ni),
    .ref_avail_i    (ref_avail_i),
    .msref_active_i (msref_active_i),
    .mode_i         (mode_i),
    .act_ref_i      (act_ref_i),
    .los_i          (los_i),
    .lol_i          (lol_i),
    .host_rd_i      (host_rd_i),
    .host_wr_i      (host_wr_i),
    .host_addr_i    (host_addr_i),
    .host_wdata_i   (host_wdata_i),
    .host_rdata_o   (host_rdata_o),
    .host_rvalid_o  (host_rvalid_o),
    .irq_o          (irq_o)
  );

  task automatic check(input bit ok, input string req, input logic [7:0] act, input logic [7:0] exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s: actual %02h expected %02h", req, act, exp);
    end
  endtask

  // one clock step: drive at the falling edge, sample at the next falling edge
  task automatic step(input logic [3:0] av, input logic ac, input logic [5:0] md,
                      input logic [1:0] ix, input logic ls, input logic ll,
                      input logic rd, input logic wr, input logic [7:0] ad,
                      input logic [7:0] wd, input string req);
    logic [7:0] p, nev, nen, exp_rd;
    p    = '0;
    p[0] = |(m_av & ~av);
    p[1] = |(~m_av & av);
    p[2] = m_ac & ~ac;
    p[3] = ~m_ac & ac;
    p[4] = ({md, ll, ls} != {m_md, m_ll, m_ls});
    p[5] = (ix != m_ix);
    p[6] = ls & ~m_ls;
    p[7] = ll & ~m_ll;
    if (!m_armed) p = '0;
    case (ad)
      8'h11:   exp_rd = {m_md, m_ll, m_ls};
      8'h12:   exp_rd = m_evt;
      8'h13:   exp_rd = m_en;
      default: exp_rd = 8'h00;
    endcase
    nev = ((rd && ad == 8'h12) ? 8'h00 : m_evt) | p;
    nen = (wr && ad == 8'h13) ? wd : m_en;
    ref_avail_i = av; msref_active_i = ac; mode_i = md; act_ref_i = ix;
    los_i = ls; lol_i = ll;
    host_rd_i = rd; host_wr_i = wr; host_addr_i = ad; host_wdata_i = wd;
    @(posedge clk_i);
    @(negedge clk_i);
    host_rd_i = 1'b0; host_wr_i = 1'b0;
    m_av = av; m_ac = ac; m_md = md; m_ix = ix; m_ls = ls; m_ll = ll;
    m_evt = nev; m_en = nen; m_armed = 1'b1;
    check(irq_o == |(nev & nen), "R8 irq", {7'd0, irq_o}, {7'd0, |(nev & nen)});
    check(host_rvalid_o == rd, "R9 rvalid", {7'd0, host_rvalid_o}, {7'd0, rd});
    if (rd) check(host_rdata_o == exp_rd, req, host_rdata_o, exp_rd);
  endtask

  task automatic set_in(input logic [3:0] av, input logic ac, input logic [5:0] md,
                        input logic [1:0] ix, input logic ls, input logic ll);
    step(av, ac, md, ix, ls, ll, 1'b0, 1'b0, 8'h00, 8'h00, "none");
  endtask

  task automatic rd_reg(input logic [7:0] ad, input string req);
    step(m_av, m_ac, m_md, m_ix, m_ls, m_ll, 1'b1, 1'b0, ad, 8'h00, req);
  endtask

  task automatic wr_reg(input logic [7:0] ad, input logic [7:0] wd);
    step(m_av, m_ac, m_md, m_ix, m_ls, m_ll, 1'b0, 1'b1, ad, wd, "none");
  endtask

  task automatic do_reset();
    rst_ni = 1'b0;
    ref_avail_i = '0; msref_active_i = 1'b0; mode_i = '0; act_ref_i = '0;
    los_i = 1'b0; lol_i = 1'b0; host_rd_i = 1'b0; host_wr_i = 1'b0;
    m_av = '0; m_ac = 1'b0; m_md = '0; m_ix = '0; m_ls = 1'b0; m_ll = 1'b0;
    m_evt = '0; m_en = '0; m_armed = 1'b0;
    repeat (3) @(negedge clk_i);
    check(irq_o == 1'b0, "R12 irq in reset", {7'd0, irq_o}, 8'h00);
    check(host_rvalid_o == 1'b0, "R12 rvalid in reset", {7'd0, host_rvalid_o}, 8'h00);
    check(host_rdata_o == 8'h00, "R12 rdata in reset", host_rdata_o, 8'h00);
    rst_ni = 1'b1;
  endtask

  initial begin
    #(200000 * 5);
    n_fail++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("  End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end

  initial begin
    @(negedge clk_i);
    do_reset();

    // R12: the first cycle only loads copies, even from nonzero inputs
    set_in(4'hF, 1'b1, 6'h2A, 2'd2, 1'b0, 1'b0);
    rd_reg(8'h12, "R12 no event after reset");
    rd_reg(8'h13, "R12 enable reset value");

    // R11: every enable value writes and reads back
    for (int v = 0; v < 256; v++) begin
      wr_reg(8'h13, 8'(v));
      rd_reg(8'h13, "R11 enable readback");
    end
    wr_reg(8'h12, 8'h00);
    wr_reg(8'h11, 8'h00);
    wr_reg(8'h14, 8'h00);
    rd_reg(8'h13, "R11 other writes ignored");
    rd_reg(8'h12, "R11 event untouched by write");

    // R7: masked events still logged, irq stays low
    wr_reg(8'h13, 8'h00);
    set_in(m_av, 1'b0, m_md, m_ix, m_ls, m_ll);
    set_in(m_av, 1'b1, m_md, m_ix, m_ls, m_ll);
    set_in(m_av, m_ac, m_md, m_ix, m_ls, m_ll);
    rd_reg(8'h12, "R7 masked events logged");
    wr_reg(8'h13, 8'hFF);

    // R1 / R2: every pair of old and new availability vectors
    for (int o = 0; o < 16; o++) begin
      for (int n = 0; n < 16; n++) begin
        set_in(4'(o), m_ac, m_md, m_ix, m_ls, m_ll);
        rd_reg(8'h12, "R1/R2 clear");
        set_in(4'(n), m_ac, m_md, m_ix, m_ls, m_ll);
        rd_reg(8'h12, "R1/R2 availability edge");
      end
    end

    // R3: activity fall then rise, read separately
    set_in(m_av, 1'b0, m_md, m_ix, m_ls, m_ll);
    rd_reg(8'h12, "R3 activity fall");
    set_in(m_av, 1'b1, m_md, m_ix, m_ls, m_ll);
    rd_reg(8'h12, "R3 activity rise");

    // R4: mode changes and status readback
    for (int k = 0; k < 8; k++) begin
      set_in(m_av, m_ac, 6'(k * 9 + 1), m_ix, m_ls, m_ll);
      rd_reg(8'h12, "R4 mode change");
      rd_reg(8'h11, "R4 status readback");
    end

    // R5: every active index change
    for (int k = 0; k < 4; k++) begin
      set_in(m_av, m_ac, m_md, 2'(k + 1), m_ls, m_ll);
      rd_reg(8'h12, "R5 active ref change");
    end

    // R6: loss flags rise and fall, fault-driven switches
    set_in(m_av, m_ac, m_md, m_ix, 1'b1, 1'b0);
    rd_reg(8'h12, "R6 los rise");
    rd_reg(8'h11, "R4 status shows los");
    set_in(m_av, m_ac, m_md, m_ix, 1'b0, 1'b0);
    rd_reg(8'h12, "R6 los fall");
    set_in(m_av, m_ac, m_md, m_ix + 2'd1, 1'b0, 1'b1);
    rd_reg(8'h12, "R6 lol switch");
    set_in(m_av, m_ac, m_md, m_ix, 1'b0, 1'b0);
    set_in(m_av, m_ac, m_md, m_ix + 2'd1, 1'b1, 1'b0);
    rd_reg(8'h12, "R6 los switch");

    // R10: event in the clear cycle survives
    set_in(m_av, m_ac, m_md, m_ix, 1'b0, 1'b0);
    rd_reg(8'h12, "R10 pre-clear");
    step(m_av, m_ac, m_md, m_ix, 1'b1, 1'b0, 1'b1, 1'b0, 8'h12, 8'h00, "R10 read at event");
    rd_reg(8'h12, "R10 event kept");

    // R9: sticky across idle cycles, second read empty
    set_in(4'h0, m_ac, m_md, m_ix, m_ls, m_ll);
    repeat (5) set_in(m_av, m_ac, m_md, m_ix, m_ls, m_ll);
    rd_reg(8'h12, "R9 sticky read");
    rd_reg(8'h12, "R9 cleared after read");

    // R8: each single enable bit against a mixed event set
    for (int b = 0; b < 8; b++) begin
      wr_reg(8'h13, 8'(1 << b));
      set_in(m_av ^ 4'h5, ~m_ac, m_md, m_ix, ~m_ls, m_ll);
      set_in(m_av, m_ac, m_md, m_ix, m_ls, m_ll);
      rd_reg(8'h12, "R8 single enable");
    end

    // R13: unmapped addresses read zero
    wr_reg(8'h13, 8'hA5);
    rd_reg(8'h00, "R13 unmapped 00");
    rd_reg(8'h10, "R13 unmapped 10");
    rd_reg(8'h14, "R13 unmapped 14");
    rd_reg(8'hFF, "R13 unmapped FF");

    // R12: reset mid-run clears enable and events
    set_in(4'h0, m_ac, m_md, m_ix, m_ls, m_ll);
    @(negedge clk_i);
    do_reset();
    set_in(4'h3, 1'b1, 6'h11, 2'd1, 1'b1, 1'b1);
    rd_reg(8'h13, "R12 enable cleared");
    rd_reg(8'h12, "R12 events cleared");

    $display("  End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end

endmodule